// File: doc/BRIEF.md
# Strided Block Memory Operation Engine

This block is a sequencer for four block operations on byte memory: fill, copy, search and pairwise compare. A host loads an operation code, a source pointer, a destination pointer, a byte stride, an element count, a fill or search byte and a condition code, then pulses `start`. The engine issues one single-byte request at a time on a request/acknowledge memory port. After each element it decrements the count and moves both pointers on by the stride. A stride of zero is legal, so a whole block can be streamed to or from one fixed address.

Search stops at the first element that meets the chosen condition against the search byte. Compare walks two areas in step and stops at the first pair for which the condition fails. Either way the engine reports a `hit` flag and the number of elements that were still left, counting the one where it stopped. The host can hold the engine with `pause`, which is honoured only between elements. While it is held, `curSrc`, `curDst` and `curCount` give the live state, so the host can save it. Releasing `pause` carries the operation on from that state.

Top module: `bme_engine`

## Requirements
- R1: Fill (op=0) writes `fillValue` to dst, dst+stride, dst+2*stride and so on, `count` writes in all. `curCount` drops by exactly one for each element finished.
- R2: Copy (op=1) reads src+i*stride and writes that byte to dst+i*stride for i = 0 to count-1, in ascending order.
- R3: With stride 0, every access of an operation uses the same source address and the same destination address.
- R4: Search (op=2) reads src+i*stride and stops at the first byte b where cond(b, fillValue) holds. It then sets `hit`=1 and `resultCount`=count-i. If no byte matches, `hit`=0 and `resultCount`=0. Search writes nothing.
- R5: Condition codes, applied as cond(a,b): 0 a==b, 1 a!=b, 2 signed a<b, 3 signed a>=b, 4 unsigned a<b, 5 unsigned a>=b, 6 signed a<=b, 7 unsigned a<=b.
- R6: Compare (op=3) reads a=src+i*stride, then b=dst+i*stride, and stops at the first pair where cond(a,b) fails. It then sets `hit`=1 and `resultCount`=count-i. If every pair passes, `hit`=0 and `resultCount`=0. Compare writes nothing.
- R7: With count 0, `done` rises one cycle after `start` and no memory request is issued.
- R8: `done` is a single-cycle pulse. `busy` is high from the cycle after `start` is accepted until the cycle of `done`.
- R9: While `pause` is high, the engine issues no new element and `curSrc`, `curDst` and `curCount` hold. Releasing `pause` finishes the operation with the same result as an uninterrupted run.
- R10: Once `memReq` is raised, `memReq`, `memWe`, `memAddr` and `memWdata` stay stable until the cycle in which `memAck` is high.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 0 fill, 1 copy, 2 search, 3 compare |
| cond | input | 3 | Condition code (R5) |
| srcPtr | input | AW | Initial source pointer |
| dstPtr | input | AW | Initial destination pointer |
| stride | input | AW | Byte step added to both pointers per element |
| count | input | CW | Number of elements |
| fillValue | input | 8 | Fill byte or search byte |
| pause | input | 1 | Hold between elements |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | AW | Request byte address |
| memWdata | output | 8 | Write byte |
| memRdata | input | 8 | Read byte, valid with memAck |
| memAck | input | 1 | Request completed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Search found / compare mismatched |
| resultCount | output | CW | Remaining count at the stopping element |
| curSrc | output | AW | Live source pointer |
| curDst | output | AW | Live destination pointer |
| curCount | output | CW | Live remaining count |

## Verification
Some properties are checked on every cycle by assertions. These are: the memory request stays stable until it is acknowledged, `done` lasts one cycle, a zero count finishes without a request, no request leaves while paused at an element boundary, and the count only ever drops by one. Whether fill, copy, search and compare touch the right addresses and report the right stop position can only be shown by the bench. It compares a full memory image and the reported `hit`/`resultCount` against a model, across strides including zero, signed and unsigned conditions, a pause in the middle of an operation, and a `start` pulse that arrives while the engine is busy.

// File: rtl/bme_pkg.sv
package bme_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {OP_FILL = 2'd0, OP_COPY = 2'd1, OP_SEARCH = 2'd2, OP_COMPARE = 2'd3} opKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture operands
    logic latchA;    // capture first read byte
    logic latchB;    // capture second read byte
    logic advance;   // step pointers, decrement count
    logic stopHit;   // record hit and remaining count
    logic useDst;    // address from destination pointer
    logic fillSel;   // write data is the fill byte
    logic againstB;  // condition right operand is second byte
  } strobe_t;

  // Branch-style condition, R5 encoding
  function automatic logic condHolds(input logic [2:0] c, input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] b);
    case (c)
      3'd0: condHolds = (a == b);
      3'd1: condHolds = (a != b);
      3'd2: condHolds = ($signed(a) < $signed(b));
      3'd3: condHolds = ($signed(a) >= $signed(b));
      3'd4: condHolds = (a < b);
      3'd5: condHolds = (a >= b);
      3'd6: condHolds = ($signed(a) <= $signed(b));
      default: condHolds = (a <= b);
    endcase
  endfunction
endpackage

// File: rtl/bme_dpath.sv
module bme_dpath import bme_pkg::*; #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [AW-1:0]     srcIn,
  input  logic [AW-1:0]     dstIn,
  input  logic [AW-1:0]     strideIn,
  input  logic [CW-1:0]     countIn,
  input  logic [BYTE_W-1:0] fillIn,
  input  logic [2:0]        condIn,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [AW-1:0]     memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              condTrue,
  output logic              cntIsOne,
  output logic              startZero,
  output logic              hit,
  output logic [CW-1:0]     resultCount,
  output logic [AW-1:0]     curSrc,
  output logic [AW-1:0]     curDst,
  output logic [CW-1:0]     curCount
);
  logic [AW-1:0]     srcQ, dstQ, strideQ;
  logic [CW-1:0]     cntQ, resQ;
  logic [BYTE_W-1:0] fillQ, byteA, byteB;
  logic [2:0]        condQ;
  logic              hitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ <= '0; dstQ <= '0; strideQ <= '0; cntQ <= '0; resQ <= '0;
      fillQ <= '0; byteA <= '0; byteB <= '0; condQ <= '0; hitQ <= 1'b0;
    end else begin
      if (strb.load) begin
        srcQ <= srcIn; dstQ <= dstIn; strideQ <= strideIn; cntQ <= countIn;
        fillQ <= fillIn; condQ <= condIn; hitQ <= 1'b0; resQ <= '0;
      end
      if (strb.latchA) byteA <= memRdata;
      if (strb.latchB) byteB <= memRdata;
      if (strb.advance) begin
        srcQ <= srcQ + strideQ;
        dstQ <= dstQ + strideQ;
        cntQ <= cntQ - CW'(1);
      end
      if (strb.stopHit) begin
        hitQ <= 1'b1;
        resQ <= cntQ;
      end
    end
  end

  assign memAddr     = strb.useDst ? dstQ : srcQ;
  assign memWdata    = strb.fillSel ? fillQ : byteA;
  assign condTrue    = condHolds(condQ, byteA, strb.againstB ? byteB : fillQ);
  assign cntIsOne    = (cntQ == CW'(1));
  assign startZero   = (countIn == '0);
  assign hit         = hitQ;
  assign resultCount = resQ;
  assign curSrc      = srcQ;
  assign curDst      = dstQ;
  assign curCount    = cntQ;

  // R1: outside a fresh load the count only ever steps down by one
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.load) && cntQ != $past(cntQ)) |-> (cntQ == $past(cntQ) - CW'(1)));
endmodule

// File: rtl/bme_ctrl.sv
module bme_ctrl import bme_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       pause,
  input  logic       memAck,
  input  logic       condTrue,
  input  logic       cntIsOne,
  input  logic       startZero,
  output strobe_t    strb,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output logic       done
);
  typedef enum logic [2:0] {S_IDLE, S_ELEM, S_RDA, S_RDB, S_WR, S_EVAL, S_ADV, S_FIN} state_e;
  state_e  stateQ, stateD;
  opKind_e opQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      opQ    <= OP_FILL;
    end else begin
      stateQ <= stateD;
      if (stateQ == S_IDLE && start) opQ <= opKind_e'(op);
    end
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    strb.useDst   = (stateQ == S_RDB) || (stateQ == S_WR);
    strb.fillSel  = (opQ == OP_FILL);
    strb.againstB = (opQ == OP_COMPARE);
    case (stateQ)
      S_IDLE: if (start) begin
        strb.load = 1'b1;
        stateD = startZero ? S_FIN : S_ELEM;
      end
      S_ELEM: if (!pause) stateD = (opQ == OP_FILL) ? S_WR : S_RDA;
      S_RDA: if (memAck) begin
        strb.latchA = 1'b1;
        case (opQ)
          OP_COPY:   stateD = S_WR;
          OP_SEARCH: stateD = S_EVAL;
          default:   stateD = S_RDB;
        endcase
      end
      S_RDB: if (memAck) begin
        strb.latchB = 1'b1;
        stateD = S_EVAL;
      end
      S_WR: if (memAck) stateD = S_ADV;
      S_EVAL: begin
        if ((opQ == OP_SEARCH) ? condTrue : !condTrue) begin
          strb.stopHit = 1'b1;
          stateD = S_FIN;
        end else stateD = S_ADV;
      end
      S_ADV: begin
        strb.advance = 1'b1;
        stateD = cntIsOne ? S_FIN : S_ELEM;
      end
      default: stateD = S_IDLE;
    endcase
  end

  assign memReq = (stateQ == S_RDA) || (stateQ == S_RDB) || (stateQ == S_WR);
  assign memWe  = (stateQ == S_WR);
  assign busy   = (stateQ != S_IDLE);
  assign done   = (stateQ == S_FIN);

  // R10: an unacknowledged request keeps its kind
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && memWe == $past(memWe)));
  // R8: completion lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: zero count finishes without touching memory
  assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_IDLE && start && startZero) |=> (done && !memReq));
  // R9: a held boundary issues nothing
  assert_pause_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_ELEM && pause) |=> !memReq);
endmodule

// File: rtl/bme_engine.sv
module bme_engine import bme_pkg::*; #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [2:0]        cond,
  input  logic [AW-1:0]     srcPtr,
  input  logic [AW-1:0]     dstPtr,
  input  logic [AW-1:0]     stride,
  input  logic [CW-1:0]     count,
  input  logic [BYTE_W-1:0] fillValue,
  input  logic              pause,
  output logic              memReq,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [BYTE_W-1:0] memWdata,
  input  logic [BYTE_W-1:0] memRdata,
  input  logic              memAck,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [CW-1:0]     resultCount,
  output logic [AW-1:0]     curSrc,
  output logic [AW-1:0]     curDst,
  output logic [CW-1:0]     curCount
);
  strobe_t strb;
  logic    condTrue, cntIsOne, startZero;

  bme_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .pause(pause), .memAck(memAck),
    .condTrue(condTrue), .cntIsOne(cntIsOne), .startZero(startZero),
    .strb(strb), .memReq(memReq), .memWe(memWe), .busy(busy), .done(done)
  );

  bme_dpath #(.AW(AW), .CW(CW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .srcIn(srcPtr), .dstIn(dstPtr), .strideIn(stride), .countIn(count),
    .fillIn(fillValue), .condIn(cond), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .condTrue(condTrue),
    .cntIsOne(cntIsOne), .startZero(startZero), .hit(hit), .resultCount(resultCount),
    .curSrc(curSrc), .curDst(curDst), .curCount(curCount)
  );

  // R10: address and write data hold until acknowledged
  assert_bus_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memWdata)));
endmodule

// File: tb/bme_engine_test.sv
module bme_engine_test;
  localparam int PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 16;

  typedef struct packed {
    logic [1:0] op;
    logic [2:0] cond;
    logic [7:0] src;
    logic [7:0] dst;
    logic [7:0] stride;
    logic [7:0] cnt;
    logic [7:0] val;
    logic       pokeEn;
    logic [7:0] pokeA;
    logic [7:0] pokeV;
    logic       expHit;
    logic [7:0] expRes;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 8'h00, 8'h40, 8'd4, 8'd5,  8'hA5, 1'b0, 8'h00, 8'h00, 1'b0, 8'd0}, // R1 fill stride 4
    '{2'd1, 3'd0, 8'h10, 8'h80, 8'd1, 8'd6,  8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'd0}, // R2 copy
    '{2'd1, 3'd0, 8'h20, 8'hC0, 8'd0, 8'd3,  8'h00, 1'b1, 8'h20, 8'h5A, 1'b0, 8'd0}, // R3 stride 0
    '{2'd2, 3'd0, 8'h00, 8'h00, 8'd2, 8'd10, 8'h08, 1'b0, 8'h00, 8'h00, 1'b1, 8'd6}, // R4 EQ
    '{2'd2, 3'd4, 8'h30, 8'h00, 8'd1, 8'd4,  8'h05, 1'b1, 8'h32, 8'h01, 1'b1, 8'd2}, // R4 LTU
    '{2'd2, 3'd2, 8'h70, 8'h00, 8'd8, 8'd4,  8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 8'd2}, // R5 signed LT
    '{2'd2, 3'd3, 8'h10, 8'h00, 8'd1, 8'd3,  8'h7F, 1'b0, 8'h00, 8'h00, 1'b0, 8'd0}, // R4 none
    '{2'd3, 3'd0, 8'h20, 8'h20, 8'd1, 8'd5,  8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'd0}, // R6 all equal
    '{2'd3, 3'd1, 8'h10, 8'h50, 8'd1, 8'd4,  8'h00, 1'b1, 8'h52, 8'h12, 1'b1, 8'd2}, // R6 NE fails
    '{2'd3, 3'd4, 8'h10, 8'h20, 8'd4, 8'd3,  8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'd0}, // R6 LTU pass
    '{2'd3, 3'd2, 8'h70, 8'h90, 8'd8, 8'd3,  8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 8'd3}, // R5 signed LT
    '{2'd3, 3'd7, 8'h10, 8'h10, 8'd1, 8'd3,  8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'd0}, // R5 LEU
    '{2'd3, 3'd6, 8'h30, 8'h31, 8'd2, 8'd3,  8'h00, 1'b1, 8'h35, 8'h00, 1'b1, 8'd1}  // R5 signed LE
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, pause = 1'b0;
  logic [1:0] op = '0;
  logic [2:0] cond = '0;
  logic [AW-1:0] srcPtr = '0, dstPtr = '0, stride = '0;
  logic [CW-1:0] count = '0;
  logic [7:0] fillValue = '0;
  logic memReq, memWe, busy, done, hit;
  logic [AW-1:0] memAddr, curSrc, curDst;
  logic [7:0] memWdata;
  logic [7:0] memRdata = '0;
  logic memAck = 1'b0;
  logic [CW-1:0] resultCount, curCount;

  logic [7:0] mem [256];
  logic [7:0] model [256];
  logic loadMem = 1'b0, pokeNow = 1'b0;
  logic [7:0] pokeAddr = '0, pokeVal = '0;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  bme_engine #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .cond(cond), .srcPtr(srcPtr),
    .dstPtr(dstPtr), .stride(stride), .count(count), .fillValue(fillValue), .pause(pause),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .busy(busy), .done(done), .hit(hit),
    .resultCount(resultCount), .curSrc(curSrc), .curDst(curDst), .curCount(curCount)
  );

  // Bench memory: acknowledges one cycle after a request appears
  always @(posedge clk) begin
    if (loadMem) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i);
      if (pokeNow) mem[pokeAddr] <= pokeVal;
    end
    memAck <= memReq && !memAck;
    if (memReq && !memAck) begin
      if (memWe) mem[memAddr[7:0]] <= memWdata;
      memRdata <= mem[memAddr[7:0]];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic initMem(input bit pe, input logic [7:0] pa, input logic [7:0] pv);
    @(negedge clk);
    loadMem = 1'b1; pokeNow = pe; pokeAddr = pa; pokeVal = pv;
    @(negedge clk);
    loadMem = 1'b0; pokeNow = 1'b0;
    for (int i = 0; i < 256; i++) model[i] = 8'(i);
    if (pe) model[pa] = pv;
  endtask

  task automatic applyModel(input logic [1:0] o, input logic [7:0] s, input logic [7:0] d,
                            input logic [7:0] st, input logic [7:0] n, input logic [7:0] v);
    for (int i = 0; i < int'(n); i++) begin
      if (o == 2'd0) model[8'(d + 8'(i) * st)] = v;
      if (o == 2'd1) model[8'(d + 8'(i) * st)] = model[8'(s + 8'(i) * st)];
    end
  endtask

  task automatic launch(input logic [1:0] o, input logic [2:0] c, input logic [7:0] s,
                        input logic [7:0] d, input logic [7:0] st, input logic [7:0] n, input logic [7:0] v);
    @(negedge clk);
    op = o; cond = c; srcPtr = AW'(s); dstPtr = AW'(d); stride = AW'(st);
    count = CW'(n); fillValue = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string req, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 4000 && !seen; k++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    check(seen, req, 0, 1);
  endtask

  task automatic checkMem(input string req);
    int errs = 0;
    int firstBad = -1;
    for (int i = 0; i < 256; i++)
      if (mem[i] !== model[i]) begin
        errs++;
        if (firstBad < 0) firstBad = i;
      end
    check(errs == 0, req, firstBad < 0 ? 0 : int'(mem[firstBad]), firstBad < 0 ? 0 : int'(model[firstBad]));
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    int reqSeen;
    logic [CW-1:0] heldCnt;
    logic [AW-1:0] heldDst;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state (R8)
    check(!done && !busy && !memReq && curCount == '0, "R8 reset idle", int'({done, busy, memReq}), 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      initMem(VECS[v].pokeEn, VECS[v].pokeA, VECS[v].pokeV);
      applyModel(VECS[v].op, VECS[v].src, VECS[v].dst, VECS[v].stride, VECS[v].cnt, VECS[v].val);
      launch(VECS[v].op, VECS[v].cond, VECS[v].src, VECS[v].dst, VECS[v].stride, VECS[v].cnt, VECS[v].val);
      waitDone("R8 done arrives", seen);
      check(hit == VECS[v].expHit, "R4/R6 hit", int'(hit), int'(VECS[v].expHit));
      check(resultCount == CW'(VECS[v].expRes), "R4/R6 resultCount", int'(resultCount), int'(VECS[v].expRes));
      @(negedge clk);
      check(!done, "R8 done one cycle", int'(done), 0);
      checkMem("R1/R2/R3 memory image");
    end

    // R7: zero count, no request
    initMem(1'b0, 8'h00, 8'h00);
    reqSeen = 0;
    launch(2'd0, 3'd0, 8'h00, 8'h10, 8'd1, 8'd0, 8'hEE);
    check(done, "R7 done one cycle after start", int'(done), 1);
    for (int k = 0; k < 4; k++) begin
      if (memReq) reqSeen++;
      @(negedge clk);
    end
    check(reqSeen == 0, "R7 no request", reqSeen, 0);
    checkMem("R7 memory untouched");

    // R9 / R11: pause mid-fill, stray start while busy
    initMem(1'b0, 8'h00, 8'h00);
    applyModel(2'd0, 8'h00, 8'hA0, 8'd1, 8'd4, 8'h3C);
    launch(2'd0, 3'd0, 8'h00, 8'hA0, 8'd1, 8'd4, 8'h3C);
    for (int k = 0; k < 200 && curCount != CW'(2); k++) @(negedge clk);
    pause = 1'b1;
    repeat (6) @(negedge clk);
    heldCnt = curCount; heldDst = curDst;
    check(heldCnt == CW'(2) && heldDst == AW'(8'hA2), "R9 held at boundary", int'(heldDst), 'hA2);
    reqSeen = 0;
    op = 2'd0; dstPtr = AW'(8'h00); count = CW'(5); fillValue = 8'h77; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (memReq) reqSeen++;
      @(negedge clk);
    end
    check(reqSeen == 0, "R9 no request while paused", reqSeen, 0);
    check(curCount == heldCnt && curDst == heldDst, "R9 state held", int'(curCount), int'(heldCnt));
    pause = 1'b0;
    waitDone("R9 resumes to done", seen);
    @(negedge clk);
    checkMem("R11 stray start ignored, R9 result");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule